// File: doc/BRIEF.md
# Prototype Correlation Max Engine

This block scores one stored prototype against a set of pooled feature maps and reports only the strongest response. The feature maps come in several scales, each scale holding one square map per orientation. The prototype is a square patch with one layer per orientation. After the host has written every scale of the feature set and the prototype, a single start pulse begins the job. For every scale and every position where the patch fits, the block computes the correlation: the sum, over all orientations and all patch taps, of the fixed-point product of feature and prototype values.

The work runs one orientation at a time. A single multiply-accumulate unit builds the per-orientation sum for each position. The finished sum is then added into an on-chip scratchpad that holds one running total per position of the current scale. When every orientation of a scale has been added, a scan pass compares each scratchpad total with a running global maximum. No correlation map leaves the block. When the last scale has been scanned, one word carries the maximum out, together with a one-cycle done pulse.

Scale `s` uses a map of side `MAP_SIDE - s*SIDE_STEP`, with the top-left corner of the stored plane holding the map. A new job restarts the maximum from the most negative value, so results from earlier prototypes never carry over.

Top module: `proto_match_max`

## Requirements
- R1: The patch side is 4*(patch_sel+1), so codes 0, 1, 2 and 3 select 4, 8, 12 and 16. The patch depth equals NUM_ORI. patch_sel is sampled on the cycle that start is accepted.
- R2: max_out is the signed maximum, over every scale s and every position (y,x), of the sum over orientation o and taps (ky,kx) of the product of feature(s,o,y+ky,x+kx) and prototype(o,ky,kx). The side of scale s is MAP_SIDE - s*SIDE_STEP.
- R3: Values are signed 32-bit, two's complement, with 24 fraction bits. Each product is the full 64-bit product shifted right arithmetically by 24 (floor), keeping the low 32 bits. Sums wrap modulo 2^32.
- R4: A position counts only where the whole patch lies inside its scale's map (y,x <= side-P). A scale whose side is below the patch side adds nothing.
- R5: A job starts only on a start pulse while busy is low. busy is high from the cycle after start until done. A start pulse while busy is ignored.
- R6: done is high for exactly one cycle per job. max_out changes only together with done and holds its value otherwise.
- R7: Feature writes go to (feat_scale, feat_ori, feat_y, feat_x), and prototype writes go to (proto_ori, proto_y, proto_x). Either kind of write is ignored while busy is high, so a running or later job sees the stored values from before the job.
- R8: Each job restarts the global maximum at 0x80000000, so a job whose responses are all negative reports a negative value even after a job with a positive result.
- R9: After reset, busy and done are low and max_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_we | input | 1 | Feature map write strobe |
| feat_scale | input | SW | Scale index of the feature write |
| feat_ori | input | OW | Orientation index of the feature write |
| feat_y | input | CW | Row of the feature write |
| feat_x | input | CW | Column of the feature write |
| feat_data | input | 32 | Feature value (signed, 24 fraction bits) |
| proto_we | input | 1 | Prototype write strobe |
| proto_ori | input | OW | Orientation layer of the prototype write |
| proto_y | input | PW | Patch row of the prototype write |
| proto_x | input | PW | Patch column of the prototype write |
| proto_data | input | 32 | Prototype value (signed, 24 fraction bits) |
| patch_sel | input | 2 | Patch side code |
| start | input | 1 | Begin a job once all scales are written |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse with the result |
| max_out | output | 32 | Global maximum response of the last job |

## Verification
The assertions watch the control contract on every cycle. They check that start from idle raises busy, that done is a single-cycle pulse seen only once the block is idle again, that max_out stays frozen outside done, and that the running maximum never falls during a job. Whether the reported value is the right maximum can only be shown by the bench. It compares against its own model of the correlation under random and directed data: each patch size, floor truncation of negative products, scales too small for the patch, writes and start pulses made during a job, and a negative result after a positive one.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

  localparam int DATA_W = 32;
  localparam int FRAC_W = 24;

  typedef logic signed [DATA_W-1:0] fx_t;

  localparam fx_t FX_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_MAC,
    ST_SCAN,
    ST_FIN
  } seq_st_t;

  // index width that stays at least one bit
  function automatic int cw(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // fixed-point product, floor towards minus infinity
  function automatic fx_t fx_mul(fx_t a, fx_t b);
    logic signed [2*DATA_W-1:0] full;
    full = (2*DATA_W)'(a) * (2*DATA_W)'(b);
    return DATA_W'(full >>> FRAC_W);
  endfunction

endpackage

// File: rtl/pmm_plane_ram.sv
module pmm_plane_ram
  import pmm_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int SIDE   = 8,
  parameter int PLW    = 2,
  parameter int CW     = 3
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [PLW-1:0] wr_plane,
  input  logic [CW-1:0]  wr_y,
  input  logic [CW-1:0]  wr_x,
  input  fx_t            wr_data,
  input  logic [PLW-1:0] rd_plane,
  input  logic [CW-1:0]  rd_y,
  input  logic [CW-1:0]  rd_x,
  output fx_t            rd_data
);

  localparam int DEPTH = PLANES * SIDE * SIDE;
  localparam int AW    = cw(DEPTH);

  function automatic logic [AW-1:0] lin(logic [PLW-1:0] p, logic [CW-1:0] y, logic [CW-1:0] x);
    return AW'((int'(p) * SIDE + int'(y)) * SIDE + int'(x));
  endfunction

  fx_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[lin(wr_plane, wr_y, wr_x)] <= wr_data;
    end
  end

  assign rd_data = mem[lin(rd_plane, rd_y, rd_x)];

endmodule

// File: rtl/pmm_seq.sv
module pmm_seq
  import pmm_pkg::*;
#(
  parameter int NUM_SCALES = 3,
  parameter int NUM_ORI    = 2,
  parameter int MAP_SIDE   = 16,
  parameter int SIDE_STEP  = 4,
  parameter int SW         = 2,
  parameter int OW         = 1,
  parameter int CW         = 4,
  parameter int PW         = 4,
  parameter int NW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    patch_sel,
  output logic          busy,
  output logic          clr_max,
  output logic          mac_en,
  output logic          tap_first,
  output logic          tap_last,
  output logic          ori_first,
  output logic          scan_en,
  output logic          fin,
  output logic [SW-1:0] sc,
  output logic [OW-1:0] ori,
  output logic [CW-1:0] fy,
  output logic [CW-1:0] fx,
  output logic [PW-1:0] ky_o,
  output logic [PW-1:0] kx_o,
  output logic [CW-1:0] pos_y,
  output logic [CW-1:0] pos_x
);

  localparam logic [SW-1:0] LAST_S = SW'(NUM_SCALES - 1);
  localparam logic [OW-1:0] LAST_O = OW'(NUM_ORI - 1);

  seq_st_t       st_q, st_n;
  logic [SW-1:0] s_q, s_n;
  logic [OW-1:0] o_q, o_n;
  logic [NW-1:0] py_q, py_n, px_q, px_n, ky_q, ky_n, kx_q, kx_n;
  logic [NW-1:0] psz_q, psz_n, lim_q, lim_n;
  logic          seq_en;
  int            side_i;

  // next-state logic
  always_comb begin
    st_n   = st_q;
    s_n    = s_q;
    o_n    = o_q;
    py_n   = py_q;
    px_n   = px_q;
    ky_n   = ky_q;
    kx_n   = kx_q;
    psz_n  = psz_q;
    lim_n  = lim_q;
    side_i = MAP_SIDE - int'(s_q) * SIDE_STEP;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          psz_n = NW'({patch_sel, 2'b00}) + NW'(4);
          s_n   = '0;
          st_n  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (side_i >= int'(psz_q)) begin
          lim_n = NW'(side_i - int'(psz_q));
          o_n   = '0;
          py_n  = '0;
          px_n  = '0;
          ky_n  = '0;
          kx_n  = '0;
          st_n  = ST_MAC;
        end else if (s_q == LAST_S) begin
          st_n = ST_FIN;
        end else begin
          s_n = s_q + SW'(1);
        end
      end
      ST_MAC: begin
        if (kx_q != psz_q - NW'(1)) begin
          kx_n = kx_q + NW'(1);
        end else begin
          kx_n = '0;
          if (ky_q != psz_q - NW'(1)) begin
            ky_n = ky_q + NW'(1);
          end else begin
            ky_n = '0;
            if (px_q != lim_q) begin
              px_n = px_q + NW'(1);
            end else begin
              px_n = '0;
              if (py_q != lim_q) begin
                py_n = py_q + NW'(1);
              end else begin
                py_n = '0;
                if (o_q != LAST_O) begin
                  o_n = o_q + OW'(1);
                end else begin
                  o_n  = '0;
                  st_n = ST_SCAN;
                end
              end
            end
          end
        end
      end
      ST_SCAN: begin
        if (px_q != lim_q) begin
          px_n = px_q + NW'(1);
        end else begin
          px_n = '0;
          if (py_q != lim_q) begin
            py_n = py_q + NW'(1);
          end else begin
            py_n = '0;
            if (s_q == LAST_S) begin
              st_n = ST_FIN;
            end else begin
              s_n  = s_q + SW'(1);
              st_n = ST_SETUP;
            end
          end
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  assign seq_en = (st_q != ST_IDLE) || start;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      s_q   <= '0;
      o_q   <= '0;
      py_q  <= '0;
      px_q  <= '0;
      ky_q  <= '0;
      kx_q  <= '0;
      psz_q <= NW'(4);
      lim_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_n;
      s_q   <= s_n;
      o_q   <= o_n;
      py_q  <= py_n;
      px_q  <= px_n;
      ky_q  <= ky_n;
      kx_q  <= kx_n;
      psz_q <= psz_n;
      lim_q <= lim_n;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign clr_max   = (st_q == ST_IDLE) && start;
  assign mac_en    = (st_q == ST_MAC);
  assign scan_en   = (st_q == ST_SCAN);
  assign fin       = (st_q == ST_FIN);
  assign tap_first = (kx_q == '0) && (ky_q == '0);
  assign tap_last  = (kx_q == psz_q - NW'(1)) && (ky_q == psz_q - NW'(1));
  assign ori_first = (o_q == '0);
  assign sc        = s_q;
  assign ori       = o_q;
  assign fy        = CW'(py_q + ky_q);
  assign fx        = CW'(px_q + kx_q);
  assign ky_o      = PW'(ky_q);
  assign kx_o      = PW'(kx_q);
  assign pos_y     = CW'(py_q);
  assign pos_x     = CW'(px_q);

endmodule

// File: rtl/pmm_accum.sv
module pmm_accum
  import pmm_pkg::*;
#(
  parameter int MAP_SIDE = 16,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_max,
  input  logic          mac_en,
  input  logic          tap_first,
  input  logic          tap_last,
  input  logic          ori_first,
  input  logic          scan_en,
  input  fx_t           feat,
  input  fx_t           wgt,
  input  logic [CW-1:0] pos_y,
  input  logic [CW-1:0] pos_x,
  output fx_t           gmax
);

  localparam int SP_DEPTH = MAP_SIDE * MAP_SIDE;
  localparam int AW       = cw(SP_DEPTH);

  fx_t           sp_mem [SP_DEPTH];
  logic [AW-1:0] sp_addr;
  fx_t           prod, tap_sum, sp_rd, sp_wr;
  fx_t           acc_q, gmax_q;
  logic          sp_we, gmax_up;

  assign sp_addr = AW'(int'(pos_y) * MAP_SIDE + int'(pos_x));
  assign prod    = fx_mul(feat, wgt);
  assign tap_sum = (tap_first ? fx_t'(0) : acc_q) + prod;
  assign sp_rd   = sp_mem[sp_addr];
  // first orientation overwrites: the scratchpad starts clean per scale
  assign sp_wr   = (ori_first ? fx_t'(0) : sp_rd) + tap_sum;
  assign sp_we   = mac_en && tap_last;
  assign gmax_up = scan_en && (sp_rd > gmax_q);

  always_ff @(posedge clk) begin
    if (sp_we) begin
      sp_mem[sp_addr] <= sp_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (mac_en) begin
      acc_q <= tap_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmax_q <= FX_MIN;
    end else if (clr_max) begin
      gmax_q <= FX_MIN;
    end else if (gmax_up) begin
      gmax_q <= sp_rd;
    end
  end

  assign gmax = gmax_q;

endmodule

// File: rtl/proto_match_max.sv
module proto_match_max
  import pmm_pkg::*;
#(
  parameter int NUM_SCALES = 3,
  parameter int NUM_ORI    = 2,
  parameter int MAP_SIDE   = 16,
  parameter int SIDE_STEP  = 4,
  localparam int PATCH_MAX = 16,
  localparam int SW        = cw(NUM_SCALES),
  localparam int OW        = cw(NUM_ORI),
  localparam int CW        = cw(MAP_SIDE),
  localparam int PW        = cw(PATCH_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          feat_we,
  input  logic [SW-1:0] feat_scale,
  input  logic [OW-1:0] feat_ori,
  input  logic [CW-1:0] feat_y,
  input  logic [CW-1:0] feat_x,
  input  logic [31:0]   feat_data,
  input  logic          proto_we,
  input  logic [OW-1:0] proto_ori,
  input  logic [PW-1:0] proto_y,
  input  logic [PW-1:0] proto_x,
  input  logic [31:0]   proto_data,
  input  logic [1:0]    patch_sel,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [31:0]   max_out
);

  localparam int FPLANES = NUM_SCALES * NUM_ORI;
  localparam int FPW     = cw(FPLANES);
  localparam int NW      = cw(MAP_SIDE + PATCH_MAX) + 1;

  logic          rs_meta, rst_sn;
  logic          busy_w, clr_max, mac_en, tap_first, tap_last, ori_first, scan_en, fin;
  logic [SW-1:0] sc;
  logic [OW-1:0] ori;
  logic [CW-1:0] fy, fx, pos_y, pos_x;
  logic [PW-1:0] ky, kx;
  logic          f_wr, p_wr;
  logic [FPW-1:0] f_wplane, f_rplane;
  fx_t           f_rd, p_rd, gmax_w;
  logic          done_q;
  fx_t           max_q;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_sn  <= rs_meta;
    end
  end

  assign f_wr = feat_we && !busy_w && (int'(feat_scale) < NUM_SCALES) && (int'(feat_ori) < NUM_ORI);
  assign p_wr = proto_we && !busy_w && (int'(proto_ori) < NUM_ORI);
  assign f_wplane = FPW'(int'(feat_scale) * NUM_ORI + int'(feat_ori));
  assign f_rplane = FPW'(int'(sc) * NUM_ORI + int'(ori));

  pmm_plane_ram #(.PLANES(FPLANES), .SIDE(MAP_SIDE), .PLW(FPW), .CW(CW)) u_fmap (
    .clk(clk), .wr_en(f_wr), .wr_plane(f_wplane), .wr_y(feat_y), .wr_x(feat_x),
    .wr_data(fx_t'(feat_data)), .rd_plane(f_rplane), .rd_y(fy), .rd_x(fx), .rd_data(f_rd)
  );

  pmm_plane_ram #(.PLANES(NUM_ORI), .SIDE(PATCH_MAX), .PLW(OW), .CW(PW)) u_proto (
    .clk(clk), .wr_en(p_wr), .wr_plane(proto_ori), .wr_y(proto_y), .wr_x(proto_x),
    .wr_data(fx_t'(proto_data)), .rd_plane(ori), .rd_y(ky), .rd_x(kx), .rd_data(p_rd)
  );

  pmm_seq #(
    .NUM_SCALES(NUM_SCALES), .NUM_ORI(NUM_ORI), .MAP_SIDE(MAP_SIDE), .SIDE_STEP(SIDE_STEP),
    .SW(SW), .OW(OW), .CW(CW), .PW(PW), .NW(NW)
  ) u_seq (
    .clk(clk), .rst_n(rst_sn), .start(start), .patch_sel(patch_sel), .busy(busy_w),
    .clr_max(clr_max), .mac_en(mac_en), .tap_first(tap_first), .tap_last(tap_last),
    .ori_first(ori_first), .scan_en(scan_en), .fin(fin), .sc(sc), .ori(ori),
    .fy(fy), .fx(fx), .ky_o(ky), .kx_o(kx), .pos_y(pos_y), .pos_x(pos_x)
  );

  pmm_accum #(.MAP_SIDE(MAP_SIDE), .CW(CW)) u_acc (
    .clk(clk), .rst_n(rst_sn), .clr_max(clr_max), .mac_en(mac_en), .tap_first(tap_first),
    .tap_last(tap_last), .ori_first(ori_first), .scan_en(scan_en), .feat(f_rd), .wgt(p_rd),
    .pos_y(pos_y), .pos_x(pos_x), .gmax(gmax_w)
  );

  // result register, loaded only on the finish cycle
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      done_q <= 1'b0;
      max_q  <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        max_q <= gmax_w;
      end
    end
  end

  assign busy    = busy_w;
  assign done    = done_q;
  assign max_out = max_q;

endmodule

// File: rtl/pmm_chk.sv
module pmm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] max_out,
  input logic [31:0] gmax
);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy) else $error("start from idle did not raise busy"); // R5

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(max_out)) else $error("max_out moved without done"); // R6

  AST_MAX_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($signed(gmax) >= $signed($past(gmax))))
    else $error("running maximum decreased"); // R8

endmodule

bind proto_match_max pmm_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .start(start), .busy(busy), .done(done),
  .max_out(max_out), .gmax(gmax_w)
);

// File: tb/sim_proto_match_max.sv
module sim_proto_match_max;

  localparam int NS = 3;
  localparam int NO = 2;
  localparam int MS = 16;
  localparam int SS = 4;
  localparam int PM = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_we = 1'b0;
  logic [1:0]  feat_scale = '0;
  logic [0:0]  feat_ori = '0;
  logic [3:0]  feat_y = '0, feat_x = '0;
  logic [31:0] feat_data = '0;
  logic        proto_we = 1'b0;
  logic [0:0]  proto_ori = '0;
  logic [3:0]  proto_y = '0, proto_x = '0;
  logic [31:0] proto_data = '0;
  logic [1:0]  patch_sel = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [31:0] max_out;

  int cmp_n = 0;
  int bad_n = 0;

  logic signed [31:0] fm [NS][NO][MS][MS];
  logic signed [31:0] pm [NO][PM][PM];

  always #10 clk = ~clk;  // 50 MHz

  proto_match_max #(.NUM_SCALES(NS), .NUM_ORI(NO), .MAP_SIDE(MS), .SIDE_STEP(SS)) u0 (
    .clk(clk), .rst_n(rst_n), .feat_we(feat_we), .feat_scale(feat_scale), .feat_ori(feat_ori),
    .feat_y(feat_y), .feat_x(feat_x), .feat_data(feat_data), .proto_we(proto_we),
    .proto_ori(proto_ori), .proto_y(proto_y), .proto_x(proto_x), .proto_data(proto_data),
    .patch_sel(patch_sel), .start(start), .busy(busy), .done(done), .max_out(max_out)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    cmp_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic signed [31:0] fxm(logic signed [31:0] a, logic signed [31:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    return 32'(p >>> 24);
  endfunction

  // R2 R3 R4 model of the reported maximum
  function automatic logic signed [31:0] ref_max(int psel);
    int p;
    logic signed [31:0] best, sum;
    p = 4 * (psel + 1);
    best = 32'sh8000_0000;
    for (int s = 0; s < NS; s++) begin
      int side;
      side = MS - s * SS;
      if (side < p) continue;
      for (int y = 0; y <= side - p; y++) begin
        for (int x = 0; x <= side - p; x++) begin
          sum = 0;
          for (int o = 0; o < NO; o++)
            for (int ky = 0; ky < p; ky++)
              for (int kx = 0; kx < p; kx++)
                sum = sum + fxm(fm[s][o][y+ky][x+kx], pm[o][ky][kx]);
          if (sum > best) best = sum;
        end
      end
    end
    return best;
  endfunction

  task automatic wr_feat(int s, int o, int y, int x, logic [31:0] d);
    @(negedge clk);
    feat_we = 1'b1; feat_scale = 2'(s); feat_ori = 1'(o);
    feat_y = 4'(y); feat_x = 4'(x); feat_data = d;
    @(negedge clk);
    feat_we = 1'b0;
  endtask

  task automatic wr_proto(int o, int y, int x, logic [31:0] d);
    @(negedge clk);
    proto_we = 1'b1; proto_ori = 1'(o);
    proto_y = 4'(y); proto_x = 4'(x); proto_data = d;
    @(negedge clk);
    proto_we = 1'b0;
  endtask

  function automatic logic signed [31:0] rnd(int lo, int hi);
    return 32'(lo + int'($urandom_range(hi - lo)));
  endfunction

  // fill every entry; mode 0 mixed sign, 1 positive feature / negative prototype, 2 constant
  task automatic load_all(int mode, int mag, logic [31:0] fc, logic [31:0] pc);
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < NO; o++)
        for (int y = 0; y < MS; y++)
          for (int x = 0; x < MS; x++) begin
            logic signed [31:0] v;
            v = (mode == 2) ? fc : (mode == 1) ? rnd(0, mag) : rnd(-mag, mag);
            fm[s][o][y][x] = v;
            wr_feat(s, o, y, x, v);
          end
    for (int o = 0; o < NO; o++)
      for (int y = 0; y < PM; y++)
        for (int x = 0; x < PM; x++) begin
          logic signed [31:0] v;
          v = (mode == 2) ? pc : (mode == 1) ? rnd(-mag, -1) : rnd(-mag, mag);
          pm[o][y][x] = v;
          wr_proto(o, y, x, v);
        end
  endtask

  task automatic kick(int psel);
    @(negedge clk);
    patch_sel = 2'(psel);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    patch_sel = 2'(~psel);
    check("R5", "busy after start", 32'(busy), 32'd1);
  endtask

  task automatic finish_job(output logic [31:0] got);
    int n;
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check("R6", "done seen", 32'(done), 32'd1);
    got = max_out;
    @(negedge clk);
    check("R6", "done single cycle", 32'(done), 32'd0);
    check("R6", "max_out held", max_out, got);
  endtask

  task automatic run_cmp(int psel, string req);
    logic [31:0] got;
    kick(psel);
    finish_job(got);
    check(req, $sformatf("maximum with patch code %0d", psel), got, ref_max(psel));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad_n++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9", "busy after reset", 32'(busy), 32'd0);
    check("R9", "done after reset", 32'(done), 32'd0);
    check("R9", "max_out after reset", max_out, 32'd0);

    // R1 R2 every patch size on mixed-sign data
    load_all(0, 1 << 22, '0, '0);
    for (int ps = 0; ps < 4; ps++) run_cmp(ps, "R1");
    load_all(0, 1 << 23, '0, '0);
    run_cmp(0, "R2");
    run_cmp(1, "R2");

    // R8 negative responses after a positive result
    load_all(1, 1 << 22, '0, '0);
    run_cmp(0, "R8");
    check("R8", "result is negative", 32'(max_out[31]), 32'd1);

    // R3 floor truncation: tiny positive times -1 gives -1 per tap; R4 only scale 0 fits a 16 patch
    load_all(2, 0, 32'd1, 32'hFFFF_FFFF);
    kick(3);
    finish_job(got);
    check("R3", "floor product sum", got, 32'(-512));
    check("R4", "single fitting position", got, ref_max(3));
    // R4 patch 12: scale 0 has 25 positions, scale 1 one, scale 2 none
    fm[1][0][0][0] = 32'sh0100_0000;
    wr_feat(1, 0, 0, 0, 32'sh0100_0000);
    run_cmp(2, "R4");

    // R7 R5 writes and start during a job are ignored
    load_all(0, 1 << 22, '0, '0);
    kick(0);
    repeat (40) @(negedge clk);
    wr_feat(0, 0, 0, 0, 32'h7F00_0000);
    wr_proto(0, 0, 0, 32'h7F00_0000);
    wr_feat(2, 1, 3, 3, 32'h7F00_0000);
    @(negedge clk);
    patch_sel = 2'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_job(got);
    check("R7", "running job unaffected by writes", got, ref_max(0));
    check("R5", "start while busy ignored", got, ref_max(0));
    repeat (20) @(negedge clk);
    check("R5", "no second job started", 32'(busy), 32'd0);
    run_cmp(3, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
    $finish;
  end

endmodule